// File: doc/BRIEF.md
# Real-Time-Clock Periodic Interrupt Controller

This block produces the programmable periodic interrupt of a real-time-clock register set. Software programs a rate code and a time-base code into a control register, enables the periodic source in a second register, and then receives an interrupt request every period. The period is counted in cycles of the block's own clock. That clock stands in for the oscillator time base, and its frequency is given by the `CLK_HZ` parameter.

A status register gathers the periodic, alarm and update flags together with a summary bit. Reading it returns the flags, clears all of them and lowers the interrupt request. The alarm and update flags are set by single-cycle event inputs from neighbouring logic. Time-of-day counting, alarm comparison and bus address decode are not part of this block.

Registers are at byte addresses 0 (control A), 1 (control B) and 2 (status C). A read returns data one cycle after `rdEn` is sampled.

Top module: `rtc_periodic_irq`

## Requirements
- R1: After reset, reads of A, B and C all return 0x00 and `irq` is low.
- R2: Register A stores write bits [6:0], with the rate code in [3:0] and the time-base code in [6:4]; its bit 7 always reads 0. Register B stores all 8 bits, with the periodic enable in bit 6. Address 3 reads 0x00.
- R3: Rate codes 3 to 15 give a period of CLK_HZ / 2^(16-code) clock cycles (8192 Hz down to 2 Hz).
- R4: Time-base code 3'b010 selects the 32 kHz base, under which rate code 1 means 256 Hz and code 2 means 128 Hz. Under any other time-base code, rate code 1 means 32768 Hz and code 2 means 16384 Hz.
- R5: Rate code 0 produces no periodic interrupt, even with the enable set.
- R6: Writing register A restarts the countdown from the full new period, so the next expiry comes exactly one period after that write.
- R7: Writing register B restarts the countdown only when bit 6 changes value. A write that leaves bit 6 unchanged does not disturb the running count.
- R8: While enabled, each expiry sets the periodic flag (C bit 6) and raises `irq`, and expiries repeat every period.
- R9: Writing register B with bit 6 = 0 lowers `irq` on the next cycle. It leaves the periodic flag set.
- R10: Status bit 7 reads 1 whenever any of update (bit 4), alarm (bit 5) or periodic (bit 6) is set. The `updateEvt` and `alarmEvt` inputs set bits 4 and 5 and do not raise `irq`.
- R11: A read of C returns its value and then clears the whole register and lowers `irq`. A flag event that arrives in the same cycle as the read is kept.
- R12: Writing register C loads bits 6:4 from the written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the time base |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 2 | Register select: 0 = A, 1 = B, 2 = C |
| wrData | input | 8 | Write data |
| updateEvt | input | 1 | Single-cycle update event, sets the update flag |
| alarmEvt | input | 1 | Single-cycle alarm event, sets the alarm flag |
| rdData | output | 8 | Read data, valid the cycle after `rdEn` |
| irq | output | 1 | Periodic interrupt request |

## Verification
The assertions assume that `wrEn` and `rdEn` are never high in the same cycle. They also assume that status-register writes do not arrive together with a read of the same register. The stimulus issues exactly one access per task and always drives the strobes low between accesses. It pulses the event inputs only in cycles with no access, except in the one scenario that deliberately overlaps an event with a status read.

// File: rtl/rtc_pic_pkg.sv
package rtc_pic_pkg;

  localparam logic [1:0] ADDR_CTLA = 2'd0;
  localparam logic [1:0] ADDR_CTLB = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;

  localparam int         PIE_POS  = 6;
  localparam logic [2:0] DIV_SLOW = 3'b010;

  // strobes from control to the countdown datapath
  typedef struct packed {
    logic       reload;
    logic       run;
    logic [3:0] rate;
    logic       slowBase;
  } dpStrobe_t;

  // log2 of the interrupt frequency for a rate code
  function automatic logic [4:0] rateShift(input logic [3:0] rate, input logic slowBase);
    logic [4:0] sh;
    case (rate)
      4'd0:    sh = 5'd16;
      4'd1:    sh = slowBase ? 5'd8 : 5'd15;
      4'd2:    sh = slowBase ? 5'd7 : 5'd14;
      default: sh = 5'd16 - {1'b0, rate};
    endcase
    return sh;
  endfunction

endpackage

// File: rtl/rtc_pic_dp.sv
module rtc_pic_dp
  import rtc_pic_pkg::*;
#(
  parameter int CLK_HZ = 65536,
  parameter int CNT_W  = 17
) (
  input  logic      clk,
  input  logic      rstN,
  input  dpStrobe_t strb,
  output logic      expire
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] period;
  logic [4:0]       shAmt;
  logic [31:0]      rawPeriod;

  always_comb begin
    shAmt     = rateShift(strb.rate, strb.slowBase);
    rawPeriod = 32'(CLK_HZ) >> shAmt;
    period    = CNT_W'(rawPeriod);
    if (period == '0) period = CNT_W'(1);
  end

  assign expire = strb.run && (strb.rate != 4'd0) && !strb.reload &&
                  (cnt <= CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strb.reload) begin
      cnt <= period;
    end else if (strb.run && (strb.rate != 4'd0)) begin
      if (cnt <= CNT_W'(1)) cnt <= period;
      else                  cnt <= cnt - CNT_W'(1);
    end
  end

endmodule

// File: rtl/rtc_pic_ctrl.sv
module rtc_pic_ctrl
  import rtc_pic_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic [1:0] addr,
  input  logic [7:0] wrData,
  input  logic       updateEvt,
  input  logic       alarmEvt,
  input  logic       expire,
  output dpStrobe_t  strb,
  output logic [7:0] rdData,
  output logic       irq,
  output logic       pieBit,
  output logic [2:0] flagBits
);

  logic [6:0] regA;
  logic [7:0] regB;
  logic       pfFlag, afFlag, ufFlag;
  logic       wrA, wrB, wrC, rdC;
  logic       pieChange;
  logic [7:0] statVal;

  assign wrA = wrEn && (addr == ADDR_CTLA);
  assign wrB = wrEn && (addr == ADDR_CTLB);
  assign wrC = wrEn && (addr == ADDR_STAT);
  assign rdC = rdEn && (addr == ADDR_STAT);

  assign pieChange = wrB && (wrData[PIE_POS] != regB[PIE_POS]);

  always_comb begin
    strb.reload   = wrA || pieChange;
    strb.run      = regB[PIE_POS];
    strb.rate     = wrA ? wrData[3:0] : regA[3:0];
    strb.slowBase = wrA ? (wrData[6:4] == DIV_SLOW) : (regA[6:4] == DIV_SLOW);
  end

  assign statVal  = {pfFlag | afFlag | ufFlag, pfFlag, afFlag, ufFlag, 4'b0000};
  assign pieBit   = regB[PIE_POS];
  assign flagBits = {pfFlag, afFlag, ufFlag};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regA <= '0;
      regB <= '0;
    end else begin
      if (wrA) regA <= wrData[6:0];
      if (wrB) regB <= wrData;
    end
  end

  // flags: read clears, write loads, events set (events win)
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pfFlag <= 1'b0;
      afFlag <= 1'b0;
      ufFlag <= 1'b0;
    end else begin
      if (rdC) begin
        pfFlag <= 1'b0;
        afFlag <= 1'b0;
        ufFlag <= 1'b0;
      end else if (wrC) begin
        pfFlag <= wrData[6];
        afFlag <= wrData[5];
        ufFlag <= wrData[4];
      end
      if (expire)    pfFlag <= 1'b1;
      if (alarmEvt)  afFlag <= 1'b1;
      if (updateEvt) ufFlag <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irq <= 1'b0;
    end else if (expire) begin
      irq <= 1'b1;
    end else if (rdC || (wrB && !wrData[PIE_POS])) begin
      irq <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (rdEn) begin
      case (addr)
        ADDR_CTLA: rdData <= {1'b0, regA};
        ADDR_CTLB: rdData <= regB;
        ADDR_STAT: rdData <= statVal;
        default:   rdData <= 8'h00;
      endcase
    end
  end

endmodule

// File: rtl/rtc_periodic_irq.sv
module rtc_periodic_irq
  import rtc_pic_pkg::*;
#(
  parameter int CLK_HZ = 65536
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic [1:0] addr,
  input  logic [7:0] wrData,
  input  logic       updateEvt,
  input  logic       alarmEvt,
  output logic [7:0] rdData,
  output logic       irq
);

  localparam int CNT_W = $clog2(CLK_HZ + 1);

  dpStrobe_t  strb;
  logic       expire;
  logic       pieBit;
  logic [2:0] flagBits;

  rtc_pic_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .rdEn     (rdEn),
    .addr     (addr),
    .wrData   (wrData),
    .updateEvt(updateEvt),
    .alarmEvt (alarmEvt),
    .expire   (expire),
    .strb     (strb),
    .rdData   (rdData),
    .irq      (irq),
    .pieBit   (pieBit),
    .flagBits (flagBits)
  );

  rtc_pic_dp #(.CLK_HZ(CLK_HZ), .CNT_W(CNT_W)) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .expire(expire)
  );

endmodule

// File: rtl/rtc_periodic_irq_chk.sv
module rtc_periodic_irq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic       rdEn,
  input logic [1:0] addr,
  input logic [7:0] wrData,
  input logic       updateEvt,
  input logic       alarmEvt,
  input logic       irq,
  input logic       expire,
  input logic [3:0] rateCode,
  input logic       pieBit,
  input logic [2:0] flagBits
);

  AST_RATE0_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (rateCode == 4'd0) |-> !expire); // R5

  AST_EXPIRE_SETS_PF: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> (flagBits[2] && irq)); // R8

  AST_PIE_OFF_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 2'd1 && !wrData[6]) |=> !irq); // R9

  AST_IRQ_NEEDS_PIE: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> pieBit); // R9

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == 2'd2 && !updateEvt && !alarmEvt && !expire)
      |=> (flagBits == 3'b000 && !irq)); // R11

  AST_EVENT_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (updateEvt || alarmEvt) |=> (flagBits[1:0] != 2'b00)); // R10

endmodule

bind rtc_periodic_irq rtc_periodic_irq_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .rdEn     (rdEn),
  .addr     (addr),
  .wrData   (wrData),
  .updateEvt(updateEvt),
  .alarmEvt (alarmEvt),
  .irq      (irq),
  .expire   (expire),
  .rateCode (strb.rate),
  .pieBit   (pieBit),
  .flagBits (flagBits)
);

// File: tb/rtc_periodic_irq_tb.sv
`timescale 1ns/1ps
module rtc_periodic_irq_tb;

  localparam int CLK_HZ    = 65536;
  localparam int WD_LIMIT  = 180000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wrData = 8'h00;
  logic       updateEvt = 1'b0;
  logic       alarmEvt = 1'b0;
  logic [7:0] rdData;
  logic       irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  rtc_periodic_irq #(.CLK_HZ(CLK_HZ)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .updateEvt(updateEvt), .alarmEvt(alarmEvt),
    .rdData(rdData), .irq(irq)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles >= WD_LIMIT && !done) begin
      done = 1'b1;
      errors = errors + 1;
      $display("FAIL watchdog: act %0d cycles exp < %0d", cycles, WD_LIMIT);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: act 0x%0h exp 0x%0h", tag, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [7:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [7:0] v);
    rdEn = 1'b1; addr = a;
    @(posedge clk);
    @(negedge clk);
    v = rdData;
    rdEn = 1'b0;
  endtask

  task automatic waitIrq(output int n);
    n = 0;
    while (!irq && n < 70000) begin
      @(negedge clk);
      n++;
    end
  endtask

  function automatic int expPeriod(input int code, input bit slow);
    int hz;
    case (code)
      1: hz = slow ? 256 : 32768;
      2: hz = slow ? 128 : 16384;
      3: hz = 8192;  4: hz = 4096;  5: hz = 2048;  6: hz = 1024;
      7: hz = 512;   8: hz = 256;   9: hz = 128;   10: hz = 64;
      11: hz = 32;   12: hz = 16;   13: hz = 8;    14: hz = 4;
      default: hz = 2;
    endcase
    return CLK_HZ / hz;
  endfunction

  task automatic testReset();
    logic [7:0] v;
    chk("R1 irq after reset", int'(irq), 0);
    rdReg(2'd0, v); chk("R1 reg A reset", v, 8'h00);
    rdReg(2'd1, v); chk("R1 reg B reset", v, 8'h00);
    rdReg(2'd2, v); chk("R1 reg C reset", v, 8'h00);
  endtask

  task automatic testReadback();
    logic [7:0] v;
    wrReg(2'd0, 8'hFF); rdReg(2'd0, v); chk("R2 reg A bit7 reads 0", v, 8'h7F);
    wrReg(2'd1, 8'hBF); rdReg(2'd1, v); chk("R2 reg B full byte", v, 8'hBF);
    rdReg(2'd3, v); chk("R2 address 3 reads 0", v, 8'h00);
    wrReg(2'd1, 8'h00); wrReg(2'd0, 8'h00);
    rdReg(2'd2, v);
  endtask

  // R3 R4 R8: first expiry one period after enable, then one period spacing
  task automatic testRate(input int code, input bit slow, input string tag);
    logic [7:0] v;
    int n;
    int p;
    p = expPeriod(code, slow);
    wrReg(2'd0, {1'b0, (slow ? 3'b010 : 3'b000), 4'(code)});
    wrReg(2'd1, 8'h40);
    waitIrq(n);
    chk({tag, " first period"}, n, p);
    rdReg(2'd2, v);
    chk("R8 periodic flag and summary set", v, 8'hC0);
    chk("R11 irq low after status read", int'(irq), 0);
    waitIrq(n);
    chk({tag, " spacing"}, n + 1, p);
    wrReg(2'd1, 8'h00);
    rdReg(2'd2, v);
  endtask

  task automatic testRateZero();
    logic [7:0] v;
    wrReg(2'd0, 8'h20);
    wrReg(2'd1, 8'h40);
    waitN(600);
    chk("R5 rate 0 no irq", int'(irq), 0);
    rdReg(2'd2, v); chk("R5 rate 0 no flag", v, 8'h00);
    wrReg(2'd1, 8'h00);
  endtask

  task automatic testAReload();
    logic [7:0] v;
    int n;
    wrReg(2'd0, 8'h06);
    wrReg(2'd1, 8'h40);
    waitN(40);
    wrReg(2'd0, 8'h06);
    waitIrq(n);
    chk("R6 A write restarts period", n, 64);
    wrReg(2'd1, 8'h00);
    rdReg(2'd2, v);
  endtask

  task automatic testBNoReload();
    logic [7:0] v;
    int n;
    wrReg(2'd0, 8'h06);
    wrReg(2'd1, 8'h40);
    waitN(40);
    wrReg(2'd1, 8'h44);
    waitIrq(n);
    chk("R7 B write same enable keeps count", n, 23);
    rdReg(2'd1, v); chk("R7 B readback", v, 8'h44);
    wrReg(2'd1, 8'h00);
    rdReg(2'd2, v);
  endtask

  task automatic testPieOff();
    logic [7:0] v;
    int n;
    wrReg(2'd0, 8'h03);
    wrReg(2'd1, 8'h40);
    waitIrq(n);
    chk("R9 irq raised", int'(irq), 1);
    wrReg(2'd1, 8'h00);
    chk("R9 irq dropped by enable off", int'(irq), 0);
    rdReg(2'd2, v); chk("R9 periodic flag kept", v, 8'hC0);
    rdReg(2'd2, v); chk("R11 status cleared by read", v, 8'h00);
  endtask

  task automatic testEvents();
    logic [7:0] v;
    updateEvt = 1'b1; @(negedge clk); updateEvt = 1'b0;
    chk("R10 update event no irq", int'(irq), 0);
    rdReg(2'd2, v); chk("R10 update flag", v, 8'h90);
    alarmEvt = 1'b1; @(negedge clk); alarmEvt = 1'b0;
    rdReg(2'd2, v); chk("R10 alarm flag", v, 8'hA0);
    updateEvt = 1'b1; alarmEvt = 1'b1; @(negedge clk);
    updateEvt = 1'b0; alarmEvt = 1'b0;
    rdReg(2'd2, v); chk("R10 both flags", v, 8'hB0);
  endtask

  task automatic testReadRace();
    logic [7:0] v;
    updateEvt = 1'b1;
    rdReg(2'd2, v);
    updateEvt = 1'b0;
    chk("R11 read with event returns old", v, 8'h00);
    rdReg(2'd2, v); chk("R11 event kept across read", v, 8'h90);
  endtask

  task automatic testWriteC();
    logic [7:0] v;
    wrReg(2'd2, 8'h2F);
    rdReg(2'd2, v); chk("R12 write C loads flags", v, 8'hA0);
    rdReg(2'd2, v); chk("R12 cleared after read", v, 8'h00);
  endtask

  initial begin
    waitN(3);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testReadback();
    testRate(3, 1'b0, "R3 code 3");
    testRate(6, 1'b0, "R3 code 6");
    testRate(12, 1'b0, "R3 code 12");
    testRate(1, 1'b0, "R4 code 1 fast");
    testRate(1, 1'b1, "R4 code 1 slow");
    testRate(2, 1'b0, "R4 code 2 fast");
    testRate(2, 1'b1, "R4 code 2 slow");
    testRateZero();
    testAReload();
    testBNoReload();
    testPieOff();
    testEvents();
    testReadRace();
    testWriteC();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule